// File: doc/BRIEF.md
# PWM Channel Group Controller

This block lets several PWM channel cores behave as one unit. Each channel can join or leave a group. One channel at a time may hold the control token for the group. Only the token holder may issue the three group-wide actions, and each action reaches every current member in the same clock cycle:

- apply the pending configuration (shadow to active copy),
- start all members,
- stop all members.

The channels are outside this block. They receive per-channel strobes and report back whether they are running.

Commands arrive as a 3-bit opcode together with the index of the requesting channel and a valid qualifier. The controller updates the membership mask and the token state on the clock edge that samples the command. It issues the strobes and the reject flags on that same edge, so they are visible one cycle after the command is presented.

A request from a channel that is running is refused as busy and has no effect. A token-related request that is not allowed raises an error pulse and also has no effect.

Top module: `pwm_group_ctrl`

## Requirements
- R1: After reset the membership mask is 0, no token is held, and all strobes and both flags are low.
- R2: An accepted join (opcode 0) sets the requester's bit in `memberMask`, and an accepted exit (opcode 1) clears it; the new mask is visible on the cycle after the command.
- R3: An accepted grant (opcode 2) makes the requester the token holder if no token is held. If a token is already held, the request pulses `errFlag` and the holder is unchanged.
- R4: Reclaim (opcode 3) from the holder releases the token. From any other channel, or with no token held, it pulses `errFlag` and changes nothing.
- R5: An exit by the token holder also releases the token.
- R6: Update (opcode 4) from the holder drives `updateStrobe` equal to `memberMask` for exactly one cycle, on the cycle after the command.
- R7: Enable (opcode 5) and disable (opcode 6) from the holder drive `enableStrobe` or `disableStrobe`, respectively, equal to `memberMask` for one cycle, on the cycle after the command. At most one kind of strobe is active in any cycle.
- R8: Update, enable or disable from a channel that is not the holder pulses `errFlag` and produces no strobe.
- R9: Any opcode 0 to 6 from a channel whose `chanRunning` bit is set pulses `busyFlag` only. It changes no state, raises no strobe and does not raise `errFlag`.
- R10: Opcode 7 has no effect and raises no flag.
- R11: With `cmdValid` low, nothing changes and all strobes and flags are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode: 0 join, 1 exit, 2 grant, 3 reclaim, 4 update, 5 enable, 6 disable, 7 none |
| cmdChan | input | 2 | Index of the requesting channel |
| chanRunning | input | 4 | Running status from each channel core |
| memberMask | output | 4 | Current group membership |
| grantValid | output | 1 | A channel holds the control token |
| grantOwner | output | 2 | Index of the token holder |
| updateStrobe | output | 4 | One-cycle shadow-to-active copy per channel |
| enableStrobe | output | 4 | One-cycle start per channel |
| disableStrobe | output | 4 | One-cycle stop per channel |
| errFlag | output | 1 | One-cycle pulse: token rule violated |
| busyFlag | output | 1 | One-cycle pulse: requester is running |

## Verification
Two checks can apply to one command in the same cycle. The first pair is the busy check and the token check: a running non-holder asking for an update. In that case the busy refusal must win, with no error pulse. The second pair is membership removal and token release: the holder exits. In that case both the mask bit and the token must clear on the same edge.

The bench provokes both pairs with directed commands. It then sweeps a long pseudo-random stream of opcodes, requesters and running patterns, and compares every output on every cycle against a state model built from the requirements.

// File: rtl/pwm_group_pkg.sv
package pwm_group_pkg;
  parameter int GRP_CH    = 4;
  parameter int GRP_IDX_W = $clog2(GRP_CH);
  parameter int OP_W      = 3;

  typedef enum logic [OP_W-1:0] {
    OP_JOIN    = 3'd0,
    OP_EXIT    = 3'd1,
    OP_GRANT   = 3'd2,
    OP_RECLAIM = 3'd3,
    OP_UPDATE  = 3'd4,
    OP_ENABLE  = 3'd5,
    OP_DISABLE = 3'd6,
    OP_NONE    = 3'd7
  } grpOp_e;

  typedef struct packed {
    logic                 doJoin;
    logic                 doExit;
    logic                 doGrant;
    logic                 doReclaim;
    logic                 doUpdate;
    logic                 doEnable;
    logic                 doDisable;
    logic [GRP_IDX_W-1:0] idx;
  } grpCtl_t;
endpackage

// File: rtl/pwm_group_control.sv
module pwm_group_control
  import pwm_group_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [OP_W-1:0]      cmdOp,
  input  logic [GRP_IDX_W-1:0] cmdChan,
  input  logic [GRP_CH-1:0]    chanRunning,
  input  logic                 grantValid,
  input  logic [GRP_IDX_W-1:0] grantOwner,
  output grpCtl_t              ctl,
  output logic                 errFlag,
  output logic                 busyFlag
);
  grpOp_e op;
  logic   live, isBusy, ok, isHolder, errNow;

  assign op       = grpOp_e'(cmdOp);
  assign live     = cmdValid && (op != OP_NONE);
  assign isBusy   = live && chanRunning[cmdChan];
  assign ok       = live && !isBusy;
  assign isHolder = grantValid && (grantOwner == cmdChan);

  always_comb begin
    ctl           = '0;
    ctl.idx       = cmdChan;
    errNow        = 1'b0;
    if (ok) begin
      unique case (op)
        OP_JOIN:    ctl.doJoin = 1'b1;
        OP_EXIT:    ctl.doExit = 1'b1;
        OP_GRANT:   begin ctl.doGrant   = !grantValid; errNow = grantValid; end
        OP_RECLAIM: begin ctl.doReclaim = isHolder;    errNow = !isHolder;  end
        OP_UPDATE:  begin ctl.doUpdate  = isHolder;    errNow = !isHolder;  end
        OP_ENABLE:  begin ctl.doEnable  = isHolder;    errNow = !isHolder;  end
        OP_DISABLE: begin ctl.doDisable = isHolder;    errNow = !isHolder;  end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      busyFlag <= 1'b0;
    end else begin
      errFlag  <= errNow;
      busyFlag <= isBusy;
    end
  end

  // R9: a busy refusal never also reports a token violation
  a_r9_busy_not_err: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && busyFlag));

  // R8: a rejected group action issues no decoded action
  a_r8_err_no_action: assert property (@(posedge clk) disable iff (!rstN)
    errNow |-> !(ctl.doUpdate || ctl.doEnable || ctl.doDisable || ctl.doGrant || ctl.doReclaim));
endmodule

// File: rtl/pwm_group_datapath.sv
module pwm_group_datapath
  import pwm_group_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  grpCtl_t              ctl,
  output logic [GRP_CH-1:0]    memberMask,
  output logic                 grantValid,
  output logic [GRP_IDX_W-1:0] grantOwner,
  output logic [GRP_CH-1:0]    updateStrobe,
  output logic [GRP_CH-1:0]    enableStrobe,
  output logic [GRP_CH-1:0]    disableStrobe
);
  for (genvar c = 0; c < GRP_CH; c++) begin : g_chan
    logic hit;
    assign hit = (ctl.idx == GRP_IDX_W'(c));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        memberMask[c]    <= 1'b0;
        updateStrobe[c]  <= 1'b0;
        enableStrobe[c]  <= 1'b0;
        disableStrobe[c] <= 1'b0;
      end else begin
        if (hit && ctl.doJoin)      memberMask[c] <= 1'b1;
        else if (hit && ctl.doExit) memberMask[c] <= 1'b0;
        updateStrobe[c]  <= ctl.doUpdate  && memberMask[c];
        enableStrobe[c]  <= ctl.doEnable  && memberMask[c];
        disableStrobe[c] <= ctl.doDisable && memberMask[c];
      end
    end
  end

  logic ownerLeaves;
  assign ownerLeaves = ctl.doExit && grantValid && (grantOwner == ctl.idx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantOwner <= '0;
    end else if (ctl.doGrant) begin
      grantValid <= 1'b1;
      grantOwner <= ctl.idx;
    end else if (ctl.doReclaim || ownerLeaves) begin
      grantValid <= 1'b0;
    end
  end

  // R7: never two kinds of group strobe in one cycle
  a_r7_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $countones({|updateStrobe, |enableStrobe, |disableStrobe}) <= 1);

  // R6: strobes only reach channels that are members
  a_r6_members_only: assert property (@(posedge clk) disable iff (!rstN)
    ((updateStrobe | enableStrobe | disableStrobe) & ~memberMask) == '0);

  // R3: the holder cannot change while the token stays held
  a_r3_owner_kept: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && $past(grantValid)) |-> $stable(grantOwner));

  // R11: with no action decoded, membership holds
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.doJoin || ctl.doExit) |=> $stable(memberMask));
endmodule

// File: rtl/pwm_group_ctrl.sv
module pwm_group_ctrl
  import pwm_group_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [OP_W-1:0]      cmdOp,
  input  logic [GRP_IDX_W-1:0] cmdChan,
  input  logic [GRP_CH-1:0]    chanRunning,
  output logic [GRP_CH-1:0]    memberMask,
  output logic                 grantValid,
  output logic [GRP_IDX_W-1:0] grantOwner,
  output logic [GRP_CH-1:0]    updateStrobe,
  output logic [GRP_CH-1:0]    enableStrobe,
  output logic [GRP_CH-1:0]    disableStrobe,
  output logic                 errFlag,
  output logic                 busyFlag
);
  grpCtl_t ctl;

  pwm_group_control u_control (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdChan(cmdChan),
    .chanRunning(chanRunning), .grantValid(grantValid), .grantOwner(grantOwner),
    .ctl(ctl), .errFlag(errFlag), .busyFlag(busyFlag)
  );

  pwm_group_datapath u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memberMask(memberMask),
    .grantValid(grantValid), .grantOwner(grantOwner), .updateStrobe(updateStrobe),
    .enableStrobe(enableStrobe), .disableStrobe(disableStrobe)
  );
endmodule

// File: tb/tb_pwm_group_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_group_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd7;
  logic [1:0] cmdChan = 2'd0;
  logic [3:0] chanRunning = 4'd0;
  logic [3:0] memberMask, updateStrobe, enableStrobe, disableStrobe;
  logic       grantValid, errFlag, busyFlag;
  logic [1:0] grantOwner;

  pwm_group_ctrl dut (.*);

  always #2 clk = ~clk;

  int   nVec = 0, nBad = 0;
  bit   done = 1'b0;
  logic [3:0] mMask = 4'd0;
  logic       mGrant = 1'b0;
  logic [1:0] mOwner = 2'd0;

  task automatic check(string req, logic [3:0] eU, logic [3:0] eE, logic [3:0] eD,
                       logic eErr, logic eBusy);
    logic [19:0] act, exp;
    act = {memberMask, grantValid, (grantValid ? grantOwner : 2'd0), updateStrobe,
           enableStrobe, disableStrobe, errFlag};
    exp = {mMask, mGrant, (mGrant ? mOwner : 2'd0), eU, eE, eD, eErr};
    nVec++;
    if (act !== exp || busyFlag !== eBusy) begin
      nBad++;
      $display("FAIL %s: actual %h busy %b, expected %h busy %b", req, act, busyFlag, exp, eBusy);
    end
  endtask

  // drive at a falling edge, let the rising edge take it, judge at the next falling edge
  task automatic step(logic v, logic [2:0] op, logic [1:0] ch, logic [3:0] run);
    logic [3:0] eU, eE, eD;
    logic eErr, eBusy, holder;
    string req;
    cmdValid = v; cmdOp = op; cmdChan = ch; chanRunning = run;
    eU = 0; eE = 0; eD = 0; eErr = 0; eBusy = 0;
    holder = mGrant && (mOwner == ch);
    if (!v) req = "R11";
    else if (op == 3'd7) req = "R10";
    else if (run[ch]) begin req = "R9"; eBusy = 1; end
    else begin
      case (op)
        3'd0: begin req = "R2"; mMask[ch] = 1'b1; end
        3'd1: begin
          if (holder) begin req = "R5"; mGrant = 1'b0; end else req = "R2";
          mMask[ch] = 1'b0;
        end
        3'd2: begin req = "R3"; if (mGrant) eErr = 1; else begin mGrant = 1; mOwner = ch; end end
        3'd3: begin req = "R4"; if (holder) mGrant = 0; else eErr = 1; end
        default: begin
          if (!holder) begin req = "R8"; eErr = 1; end
          else begin
            req = (op == 3'd4) ? "R6" : "R7";
            if (op == 3'd4) eU = mMask; else if (op == 3'd5) eE = mMask; else eD = mMask;
          end
        end
      endcase
    end
    @(posedge clk); @(negedge clk);
    check(req, eU, eE, eD, eErr, eBusy);
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", 0, 0, 0, 0, 0);                 // R1 reset state
    step(1, 3'd0, 2'd0, 4'd0);                  // R2 join 0
    step(1, 3'd0, 2'd2, 4'd0);                  // R2 join 2
    step(1, 3'd4, 2'd0, 4'd0);                  // R8 update without token
    step(1, 3'd2, 2'd1, 4'd0);                  // R3 grant to 1
    step(1, 3'd2, 2'd3, 4'd0);                  // R3 second grant refused
    step(1, 3'd4, 2'd1, 4'd0);                  // R6 update, mask 0101
    step(1, 3'd5, 2'd1, 4'd0);                  // R7 enable
    step(1, 3'd6, 2'd1, 4'd0);                  // R7 disable
    step(1, 3'd4, 2'd2, 4'b0100);               // R9 busy beats R8
    step(1, 3'd6, 2'd1, 4'b0010);               // R9 running holder refused
    step(1, 3'd7, 2'd1, 4'd0);                  // R10 opcode 7
    step(0, 3'd4, 2'd1, 4'd0);                  // R11 idle
    step(1, 3'd3, 2'd0, 4'd0);                  // R4 reclaim by non-holder
    step(1, 3'd0, 2'd1, 4'd0);                  // R2 holder joins
    step(1, 3'd1, 2'd1, 4'd0);                  // R5 holder exits, token freed
    step(1, 3'd2, 2'd2, 4'd0);                  // R3 grant to 2
    step(1, 3'd3, 2'd2, 4'd0);                  // R4 reclaim by holder
    for (int i = 0; i < 6000; i++) begin        // sweep all opcodes, requesters, run patterns
      logic [3:0] run;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run = lfsr[11:8] & lfsr[15:12];
      step(lfsr[7:0] != 8'h00, lfsr[2:0], lfsr[4:3], run);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule